// File: doc/BRIEF.md
# Token-Gated Device Lifecycle Controller

This block holds the security lifecycle of a root-of-trust device. After reset it waits for the fuse store to report that its initialization is done. It then reads the persisted lifecycle word and decodes it into one of fifteen lifecycle states. A word that cannot be decoded cleanly sends the block into a sticky escalation condition. While a state is loaded, the block drives a set of capability enables from that state: debug, scan, fuse provisioning, key-manager service and an owner-secret erase strobe.

Software or a debug agent asks for a move to another state by presenting a target state and a secret token. The block checks that the move is on the permitted graph. It also compares the token against the expected value for that kind of move, using a fixed-time comparison. An accepted move raises a programming request that carries the encoded target word and holds it until the fuse store acknowledges the write. The block then re-reads the stored word, and the new capabilities come only from that re-read.

Top module: `lc_gate_ctrl`

## Requirements
- R1: State index encoding: RAW=0, TEST_UNLOCKED_0..7=1..8, TEST_LOCKED=9, DEV=10, PROD=11, PROD_END=12, RMA=13, SCRAP=14. The stored 16-bit word for index s is {s, ~s, s, ~s}, with the most significant nibble first. Once the word is loaded, `state_valid_o` is high and `state_o` carries the index.
- R2: The block escalates when the stored word is flagged uncorrectable, when its four nibbles do not follow the R1 pattern, or when it carries index 15. In that case `alert_o` rises and stays high until reset, every capability output stays low, and requests get no response.
- R3: The stored word is not sampled while `otp_init_done_i` is low. During that time `state_valid_o` and `ready_o` stay low, whatever the word holds. An all-zero word is never taken as RAW: once sampled, it fails the R2 check.
- R4: Capabilities per loaded state. In RAW, TEST_LOCKED and SCRAP everything is off. In TEST_UNLOCKED_n, debug, scan and provisioning are on. In DEV, PROD and PROD_END the key manager is on. Debug in DEV follows R9, and RMA follows R10.
- R5: Permitted moves and the token each one needs:
  - RAW to TEST_UNLOCKED_n needs the unlock token.
  - TEST_UNLOCKED_k to TEST_LOCKED needs no token.
  - TEST_UNLOCKED_k to TEST_UNLOCKED_j with j>k needs the unlock token.
  - TEST_LOCKED to any TEST_UNLOCKED_n needs the unlock token.
  - Any test state to DEV, PROD or PROD_END needs the exit token.
  - PROD to RMA needs the RMA token.
  - Every state except PROD_END and SCRAP may move to SCRAP with no token.
- R6: A move off the graph, or a wrong token, is answered with an error response and produces no programming request.
- R7: On an accepted move, `prog_req_o` rises in the same cycle as the response, with `prog_word_o` holding the R1 word of the target. Both hold, and the old state and capabilities hold, until `prog_ack_i`. The stored word is then re-read and the new state is taken only from that read.
- R8: PROD_END is terminal. Every request made in it, including one for RMA or SCRAP, is rejected.
- R9: In DEV, debug is off until a request with target DEV carries the DEV debug token. That request is accepted without any programming, and it turns debug on until the next load.
- R10: When RMA is loaded, `owner_erase_o` is high for exactly the first cycle. Debug is on from the following cycle onward.
- R11: The response to a request sampled while `ready_o` is high appears as a one-cycle `rsp_valid_o` on the next cycle. It takes the same time whether the token matches or not, because the token check is a full-width XOR with an OR reduction.
- R12: Requests presented while `ready_o` is low (loading, programming or escalated) are ignored and get no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| otp_init_done_i | input | 1 | Fuse store initialization finished |
| otp_word_i | input | 16 | Stored lifecycle word |
| otp_uncorr_i | input | 1 | Stored word flagged uncorrectable |
| prog_req_o | output | 1 | Request to program a new lifecycle word |
| prog_word_o | output | 16 | Word to program |
| prog_ack_i | input | 1 | Programming finished |
| req_valid_i | input | 1 | Transition request strobe |
| req_target_i | input | 4 | Requested target state index |
| req_token_i | input | TOKEN_W | Presented token |
| tok_unlock_i | input | TOKEN_W | Expected test-unlock token |
| tok_exit_i | input | TOKEN_W | Expected test-exit token |
| tok_rma_i | input | TOKEN_W | Expected device RMA token |
| tok_devdbg_i | input | TOKEN_W | Expected DEV debug-unlock token |
| ready_o | output | 1 | Block accepts a request this cycle |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_err_o | output | 1 | Response is a rejection |
| state_valid_o | output | 1 | A decoded state is loaded |
| state_o | output | 4 | Loaded state index |
| alert_o | output | 1 | Escalation alert, sticky |
| dbg_en_o | output | 1 | Debug enable |
| scan_en_o | output | 1 | Scan enable |
| prov_en_o | output | 1 | Fuse provisioning enable |
| keymgr_en_o | output | 1 | Key-manager enable |
| owner_erase_o | output | 1 | Owner partition erase strobe |

## Verification
Each result has a fixed latency, and the bench checks it at that point:
- The response and the programming request both appear one clock after the edge that samples a request, so the bench drives on a falling edge and checks on the next one.
- After a load is enabled, whether by raising the init-done signal or by the edge that samples the write acknowledge, the decoded state and its capabilities are due one edge later. The bench checks at the falling edge after that.
- For RMA, the erase strobe is checked on that same falling edge, and debug is checked one cycle later.

The bench keeps its own state model and computes the expected response, word and capabilities from it, never from the design.

// File: rtl/lc_gate_ctrl.sv
module lc_gate_ctrl #(
  parameter int TOKEN_W = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               otp_init_done_i,
  input  logic [15:0]        otp_word_i,
  input  logic               otp_uncorr_i,
  output logic               prog_req_o,
  output logic [15:0]        prog_word_o,
  input  logic               prog_ack_i,
  input  logic               req_valid_i,
  input  logic [3:0]         req_target_i,
  input  logic [TOKEN_W-1:0] req_token_i,
  input  logic [TOKEN_W-1:0] tok_unlock_i,
  input  logic [TOKEN_W-1:0] tok_exit_i,
  input  logic [TOKEN_W-1:0] tok_rma_i,
  input  logic [TOKEN_W-1:0] tok_devdbg_i,
  output logic               ready_o,
  output logic               rsp_valid_o,
  output logic               rsp_err_o,
  output logic               state_valid_o,
  output logic [3:0]         state_o,
  output logic               alert_o,
  output logic               dbg_en_o,
  output logic               scan_en_o,
  output logic               prov_en_o,
  output logic               keymgr_en_o,
  output logic               owner_erase_o
);
  localparam int IDX_W  = 4;
  localparam int WORD_W = 4 * IDX_W;

  localparam logic [IDX_W-1:0] S_RAW   = 4'd0;
  localparam logic [IDX_W-1:0] S_TU0   = 4'd1;
  localparam logic [IDX_W-1:0] S_TU7   = 4'd8;
  localparam logic [IDX_W-1:0] S_TLK   = 4'd9;
  localparam logic [IDX_W-1:0] S_DEV   = 4'd10;
  localparam logic [IDX_W-1:0] S_PROD  = 4'd11;
  localparam logic [IDX_W-1:0] S_PEND  = 4'd12;
  localparam logic [IDX_W-1:0] S_RMA   = 4'd13;
  localparam logic [IDX_W-1:0] S_SCRAP = 4'd14;
  localparam logic [IDX_W-1:0] S_BAD   = 4'd15;

  typedef enum logic [1:0] {F_LOAD, F_IDLE, F_PROG, F_ALERT} fsm_e;
  typedef enum logic [2:0] {K_ILL, K_NONE, K_UNLOCK, K_EXIT, K_RMA, K_DEVDBG} kind_e;

  function automatic logic in_test_unlocked(logic [IDX_W-1:0] s);
    return (s >= S_TU0) && (s <= S_TU7);
  endfunction

  function automatic logic [WORD_W-1:0] encode(logic [IDX_W-1:0] s);
    return {s, ~s, s, ~s};
  endfunction

  fsm_e               fsm_q;
  logic [IDX_W-1:0]   cur_q;
  logic               devdbg_q;
  logic               erase_q;
  logic [WORD_W-1:0]  word_q;
  logic               rsp_valid_q;
  logic               rsp_err_q;

  logic [IDX_W-1:0] w_idx;
  logic             word_ok;
  assign w_idx   = otp_word_i[WORD_W-1 -: IDX_W];
  assign word_ok = !otp_uncorr_i
                 && (otp_word_i[3*IDX_W-1 -: IDX_W] == ~w_idx)
                 && (otp_word_i[2*IDX_W-1 -: IDX_W] ==  w_idx)
                 && (otp_word_i[IDX_W-1:0]          == ~w_idx)
                 && (w_idx != S_BAD);

  kind_e kind;
  always_comb begin
    kind = K_ILL;
    if (req_target_i == S_BAD || cur_q == S_PEND || cur_q == S_SCRAP) begin
      kind = K_ILL;
    end else if (req_target_i == S_SCRAP) begin
      kind = K_NONE;
    end else if (cur_q == S_RAW) begin
      if (in_test_unlocked(req_target_i)) kind = K_UNLOCK;
    end else if (in_test_unlocked(cur_q) || cur_q == S_TLK) begin
      if (req_target_i == S_TLK && cur_q != S_TLK)
        kind = K_NONE;
      else if (in_test_unlocked(req_target_i) && (cur_q == S_TLK || req_target_i > cur_q))
        kind = K_UNLOCK;
      else if (req_target_i == S_DEV || req_target_i == S_PROD || req_target_i == S_PEND)
        kind = K_EXIT;
    end else if (cur_q == S_DEV && req_target_i == S_DEV) begin
      kind = K_DEVDBG;
    end else if (cur_q == S_PROD && req_target_i == S_RMA) begin
      kind = K_RMA;
    end
  end

  logic [TOKEN_W-1:0] exp_tok;
  always_comb begin
    case (kind)
      K_UNLOCK: exp_tok = tok_unlock_i;
      K_EXIT:   exp_tok = tok_exit_i;
      K_RMA:    exp_tok = tok_rma_i;
      K_DEVDBG: exp_tok = tok_devdbg_i;
      default:  exp_tok = req_token_i;
    endcase
  end

  logic tok_mismatch, grant;
  assign tok_mismatch = |(req_token_i ^ exp_tok);
  assign grant        = (kind != K_ILL) && !tok_mismatch;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q       <= F_LOAD;
      cur_q       <= S_RAW;
      devdbg_q    <= 1'b0;
      erase_q     <= 1'b0;
      word_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      erase_q     <= 1'b0;
      case (fsm_q)
        F_LOAD: if (otp_init_done_i) begin
          if (word_ok) begin
            cur_q    <= w_idx;
            devdbg_q <= 1'b0;
            erase_q  <= (w_idx == S_RMA);
            fsm_q    <= F_IDLE;
          end else begin
            fsm_q    <= F_ALERT;
          end
        end
        F_IDLE: if (req_valid_i) begin
          rsp_valid_q <= 1'b1;
          rsp_err_q   <= !grant;
          if (grant) begin
            if (kind == K_DEVDBG) begin
              devdbg_q <= 1'b1;
            end else begin
              word_q <= encode(req_target_i);
              fsm_q  <= F_PROG;
            end
          end
        end
        F_PROG: if (prog_ack_i) fsm_q <= F_LOAD;
        default: fsm_q <= F_ALERT;
      endcase
    end
  end

  logic live, tu_now;
  assign live   = (fsm_q == F_IDLE) || (fsm_q == F_PROG);
  assign tu_now = in_test_unlocked(cur_q);

  assign ready_o       = (fsm_q == F_IDLE);
  assign alert_o       = (fsm_q == F_ALERT);
  assign prog_req_o    = (fsm_q == F_PROG);
  assign prog_word_o   = word_q;
  assign rsp_valid_o   = rsp_valid_q;
  assign rsp_err_o     = rsp_err_q;
  assign state_valid_o = live;
  assign state_o       = cur_q;

  assign dbg_en_o      = live && (tu_now || (cur_q == S_DEV && devdbg_q)
                                          || (cur_q == S_RMA && !erase_q));
  assign scan_en_o     = live && tu_now;
  assign prov_en_o     = live && tu_now;
  assign keymgr_en_o   = live && (cur_q == S_DEV || cur_q == S_PROD || cur_q == S_PEND);
  assign owner_erase_o = live && erase_q;
endmodule

// File: rtl/lc_gate_ctrl_chk.sv
module lc_gate_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        otp_init_done_i,
  input logic        req_valid_i,
  input logic        prog_req_o,
  input logic [15:0] prog_word_o,
  input logic        ready_o,
  input logic        rsp_valid_o,
  input logic        rsp_err_o,
  input logic        state_valid_o,
  input logic [3:0]  state_o,
  input logic        alert_o,
  input logic        dbg_en_o,
  input logic        scan_en_o,
  input logic        prov_en_o,
  input logic        keymgr_en_o,
  input logic        owner_erase_o
);
  // R2
  alert_caps_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o |-> !(dbg_en_o || scan_en_o || prov_en_o || keymgr_en_o || owner_erase_o));

  // R2
  alert_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o |=> alert_o);

  // R3
  load_after_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_valid_o) |-> $past(otp_init_done_i));

  // R6
  prog_only_on_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_req_o) |-> (rsp_valid_o && !rsp_err_o));

  // R7
  prog_word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_req_o && $past(prog_req_o)) |-> ($stable(prog_word_o) && $stable(state_o)
                                           && $stable(keymgr_en_o) && $stable(scan_en_o)));

  // R8
  prod_end_terminal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && state_o == 4'd12 && req_valid_i) |=> (rsp_valid_o && rsp_err_o));

  // R12
  busy_no_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o) |=> !rsp_valid_o);

  // R4
  raw_no_caps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_valid_o && state_o == 4'd0) |-> !(dbg_en_o || scan_en_o || prov_en_o || keymgr_en_o));
endmodule

bind lc_gate_ctrl lc_gate_ctrl_chk chk_i (.*);

// File: tb/lc_gate_ctrl_tb.sv
module lc_gate_ctrl_tb_top;
  localparam int TW = 64;
  localparam logic [TW-1:0] T_UNL = 64'hA5A5_1234_0F0F_9876;
  localparam logic [TW-1:0] T_EXT = 64'h3C3C_DEAD_BEEF_0101;
  localparam logic [TW-1:0] T_RMA = 64'h7777_0000_FFFF_1357;
  localparam logic [TW-1:0] T_DBG = 64'h0123_4567_89AB_CDEF;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, init_done, uncorr, ack, req_valid;
  logic [15:0] otp_word, prog_word;
  logic [3:0] req_target, state;
  logic [TW-1:0] req_token;
  logic prog_req, ready, rsp_valid, rsp_err, state_valid, alert;
  logic dbg, scan, prov, km, erase;

  lc_gate_ctrl #(.TOKEN_W(TW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .otp_init_done_i(init_done), .otp_word_i(otp_word),
    .otp_uncorr_i(uncorr), .prog_req_o(prog_req), .prog_word_o(prog_word), .prog_ack_i(ack),
    .req_valid_i(req_valid), .req_target_i(req_target), .req_token_i(req_token),
    .tok_unlock_i(T_UNL), .tok_exit_i(T_EXT), .tok_rma_i(T_RMA), .tok_devdbg_i(T_DBG),
    .ready_o(ready), .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err),
    .state_valid_o(state_valid), .state_o(state), .alert_o(alert),
    .dbg_en_o(dbg), .scan_en_o(scan), .prov_en_o(prov), .keymgr_en_o(km),
    .owner_erase_o(erase));

  int errs = 0, checks = 0;
  int cur;
  bit dd;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(int i);
    logic [3:0] x = 4'(i);
    return {x, ~x, x, ~x};
  endfunction

  // 0 illegal, 1 no token, 2 unlock, 3 exit, 4 rma, 5 dev debug
  function automatic int kind_of(int c, int t);
    bit tu_c = (c >= 1 && c <= 8);
    bit tu_t = (t >= 1 && t <= 8);
    if (t == 15 || c == 12 || c == 14) return 0;
    if (t == 14) return 1;
    if (c == 0) return tu_t ? 2 : 0;
    if (tu_c || c == 9) begin
      if (t == 9 && tu_c) return 1;
      if (tu_t && (c == 9 || t > c)) return 2;
      if (t == 10 || t == 11 || t == 12) return 3;
      return 0;
    end
    if (c == 10 && t == 10) return 5;
    if (c == 11 && t == 13) return 4;
    return 0;
  endfunction

  function automatic logic [TW-1:0] tok_of(int k);
    case (k)
      2: return T_UNL;
      3: return T_EXT;
      4: return T_RMA;
      5: return T_DBG;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  function automatic logic [4:0] caps(int c, bit d, bit ephase);
    bit tu = (c >= 1 && c <= 8);
    logic [4:0] r;
    r[4] = tu || (c == 10 && d) || (c == 13 && !ephase);
    r[3] = tu;
    r[2] = tu;
    r[1] = (c == 10 || c == 11 || c == 12);
    r[0] = (c == 13 && ephase);
    return r;
  endfunction

  task automatic check_caps(string req, bit ephase);
    logic [4:0] act = {dbg, scan, prov, km, erase};
    logic [4:0] exp = caps(cur, dd, ephase);
    chk(act == exp, req, "caps {dbg,scan,prov,km,erase}", act, exp);
  endtask

  task automatic after_load(string req);
    chk(state_valid && ready && state == 4'(cur), "R1", "loaded state", state, cur);
    if (cur == 13) begin
      chk(erase && !dbg, "R10", "erase pulse first cycle", {erase, dbg}, 2'b10);
      @(negedge clk);
      chk(!erase && dbg, "R10", "debug after erase", {erase, dbg}, 2'b01);
    end
    check_caps(req, 1'b0);
  endtask

  task automatic reset_hold();
    rst_n = 0; init_done = 0; otp_word = 16'h0000; uncorr = 0; ack = 0;
    req_valid = 0; req_target = 0; req_token = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!state_valid && !ready && !alert && !prog_req, "R3", "idle before init done",
        {state_valid, ready, alert}, 0);
  endtask

  task automatic boot(int start);
    reset_hold();
    otp_word = enc(start);
    init_done = 1;
    @(negedge clk);
    cur = start; dd = 0;
    after_load("R4");
  endtask

  task automatic boot_bad(logic [15:0] w, bit u, string what);
    reset_hold();
    otp_word = w; uncorr = u; init_done = 1;
    @(negedge clk);
    chk(alert && !state_valid, "R2", what, {alert, state_valid}, 2'b10);
    chk({dbg, scan, prov, km, erase} == 0, "R2", "caps off on alert", {dbg, scan, prov, km, erase}, 0);
    req_valid = 1; req_target = 4'd14; req_token = 0;
    @(negedge clk);
    req_valid = 0;
    chk(!rsp_valid, "R12", "no response while escalated", rsp_valid, 0);
    otp_word = enc(0); uncorr = 0;
    repeat (3) @(negedge clk);
    chk(alert && !state_valid, "R2", "alert sticky", alert, 1);
  endtask

  task automatic do_req(int tgt, bit good);
    int k = kind_of(cur, tgt);
    bit exp_err = (k == 0) || (k >= 2 && !good);
    logic [TW-1:0] tok = tok_of(k);
    if (k >= 2 && !good) tok = tok ^ (64'h1 << $urandom_range(0, 63));
    chk(ready, "R11", "ready before request", ready, 1);
    req_valid = 1; req_target = 4'(tgt); req_token = tok;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid, "R11", "response next cycle", rsp_valid, 1);
    chk(rsp_err == exp_err, (k == 0) ? "R6" : "R5", "response error", rsp_err, exp_err);
    if (exp_err) begin
      chk(!prog_req && state == 4'(cur), "R6", "no program on reject", {prog_req, state}, cur);
      check_caps("R6", 1'b0);
      return;
    end
    if (k == 5) begin
      dd = 1;
      chk(dbg && !prog_req, "R9", "dev debug unlocked", {dbg, prog_req}, 2'b10);
      return;
    end
    chk(prog_req && prog_word == enc(tgt), "R7", "program word", prog_word, enc(tgt));
    req_valid = 1; req_target = 4'd14; req_token = 0;
    @(negedge clk);
    req_valid = 0;
    chk(!rsp_valid, "R12", "request ignored while programming", rsp_valid, 0);
    repeat ($urandom_range(0, 3)) @(negedge clk);
    chk(prog_req && state == 4'(cur), "R7", "old state held while programming", state, cur);
    check_caps("R7", 1'b0);
    ack = 1; otp_word = enc(tgt);
    @(negedge clk);
    ack = 0;
    chk(!prog_req && !state_valid, "R7", "reloading after ack", {prog_req, state_valid}, 0);
    @(negedge clk);
    cur = tgt; dd = 0;
    after_load("R7");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R3 zero word sampled after init is an error, never RAW
    boot_bad(16'h0000, 1'b0, "zero word escalates");
    boot_bad(16'hF0F0, 1'b0, "index 15 escalates");
    boot_bad(enc(11) ^ 16'h0010, 1'b0, "broken pattern escalates");
    boot_bad(enc(11), 1'b1, "uncorrectable escalates");

    boot(0);
    do_req(11, 1);
    do_req(3, 0);
    do_req(3, 1);
    do_req(2, 1);
    do_req(9, 1);
    do_req(1, 1);
    do_req(11, 0);
    do_req(11, 1);
    do_req(13, 0);
    do_req(13, 1);
    do_req(11, 1);
    do_req(14, 1);
    do_req(0, 1);

    // R8 terminal state
    boot(12);
    for (int t = 0; t < 16; t++) do_req(t, 1);

    // R9 dev debug
    boot(10);
    do_req(10, 0);
    do_req(13, 1);
    do_req(10, 1);
    do_req(14, 1);

    for (int e = 0; e < 60; e++) begin
      boot($urandom_range(0, 14));
      for (int n = 0; n < 8; n++)
        do_req($urandom_range(0, 15), $urandom_range(0, 9) < 7);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule